// File: doc/BRIEF.md
# Half-Duplex Differential Bus Master Sequencer

This block runs the master side of a shared two-wire half-duplex bus on which up to 32 nodes hang. The master is node 0; every slave has a nonzero identifier. A requester hands the block one request: a slave identifier, a payload length, an expected reply length and a reply timeout in clock cycles. The block turns on the line driver and sends the identifier byte ahead of the payload. The payload bytes are pulled from a ready/valid source, and every byte goes to a byte-serial transmitter.

Once the transmitter reports that its shift register is empty, the block drops the driver so the slave can answer. It then forwards the reply bytes that arrive from the byte-serial receiver. It stops when the expected count is reached or the timeout runs out, and it reports the outcome through status flags. The receiver stays on at all times, so the bytes the master hears while driving are its own echo. These bytes are thrown away.

States: `ST_IDLE` (waiting; the only state that accepts a request), `ST_ADDR` (offer the identifier byte), `ST_PAYLOAD` (stream payload bytes), `ST_DRAIN` (driver still on, wait for transmitter empty), `ST_LISTEN` (driver off, collect reply, run timer), `ST_FINISH` (one-cycle completion).

Transitions:
- IDLE→ADDR on an accepted request with a nonzero identifier.
- IDLE→FINISH on a request for identifier 0.
- ADDR→PAYLOAD, or ADDR→DRAIN when the payload length is 0, once the identifier byte is taken.
- PAYLOAD→DRAIN on the last payload handshake.
- DRAIN→LISTEN, or DRAIN→FINISH when the reply length is 0, once the transmitter reports empty.
- LISTEN→FINISH on the last reply byte or on timeout.
- FINISH→IDLE always.

Top module: `rs485_master_ctrl`

## Requirements
- R1: The first byte offered to the transmitter in a transaction is {3'b000, slave_id}. It is followed by exactly `req_tx_len` payload bytes in the order the payload source presents them.
- R2: `drv_en` is high whenever `utx_valid` is high. It stays high while the transmitter is still shifting any byte of the transaction, that is, while `utx_idle` is low. The transmitter lowers `utx_idle` at the edge where it accepts a byte.
- R3: `drv_en` falls only in the cycle after `utx_idle` was seen high once the last byte had been handed over. Listening begins in that same cycle.
- R4: Bytes that arrive on `urx_valid` while `drv_en` is high are discarded. `rpl_valid` is high only while listening, and it carries `urx_data` unchanged.
- R5: A transaction completes after `req_rx_len` reply bytes. With `req_rx_len` = 0 it completes in the cycle in which `drv_en` falls, and nothing is forwarded.
- R6: If the reply is still incomplete after `req_timeout` cycles in the listening state, the block completes with `st_timeout` = 1. The `done` pulse comes in the cycle after the last listening cycle. A timeout value of 0 acts as 1.
- R7: `req_ready` is high only in the idle state. A request presented while busy has no effect. `busy` is high from the cycle after acceptance until the cycle after `done`.
- R8: A request for identifier 0 completes with `st_bad_addr` = 1, and `drv_en` is never raised and no byte is sent.
- R9: `done` is a single-cycle pulse. `st_timeout` and `st_bad_addr` hold their value until the next request is accepted.
- R10: After reset: `busy`, `drv_en`, `done`, `st_timeout` and `st_bad_addr` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request accepted (idle only) |
| req_slave | input | SLAVE_W | Target slave identifier |
| req_tx_len | input | LEN_W | Payload byte count |
| req_rx_len | input | LEN_W | Expected reply byte count |
| req_timeout | input | TMO_W | Reply window in clock cycles |
| pl_valid | input | 1 | Payload byte available |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte consumed |
| utx_valid | output | 1 | Byte offered to transmitter |
| utx_data | output | 8 | Byte to transmit |
| utx_ready | input | 1 | Transmitter takes byte |
| utx_idle | input | 1 | Transmitter shift register empty |
| urx_valid | input | 1 | Receiver byte strobe |
| urx_data | input | 8 | Received byte |
| drv_en | output | 1 | Line driver enable |
| rpl_valid | output | 1 | Reply byte strobe |
| rpl_data | output | 8 | Reply byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Completion pulse |
| st_timeout | output | 1 | Last transaction timed out |
| st_bad_addr | output | 1 | Last request named node 0 |

## Verification
The assertions check the following on every cycle:
- a transmit offer never appears without the driver enabled;
- no reply byte is forwarded while driving;
- the driver falls only after the transmitter reported empty;
- the first byte after the driver rises carries the latched identifier;
- `req_ready` and `busy` never overlap;
- `done` is a single pulse;
- the timeout flag rises only together with `done`.

The bench scenarios cover what needs a whole transaction to show. These are the byte order on the wire, echo rejection, completion by count, the exact length of the timeout window, the zero-length cases, rejection of node 0, and the fact that a request made while busy changes nothing.

// File: rtl/rs485_mst_pkg.sv
package rs485_mst_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PAYLOAD,
        ST_DRAIN,
        ST_LISTEN,
        ST_FINISH
    } mst_state_t;
endpackage

// File: rtl/rs485_byte_counter.sv
module rs485_byte_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/rs485_reply_timer.sv
module rs485_reply_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] elapsed;
    logic [W:0]   next_ext;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            elapsed <= '0;
        end else if (!expired) begin
            elapsed <= elapsed + W'(1);
        end
    end

    // cycle k of the window expires when k+1 reaches the limit; limit 0 acts as 1
    assign next_ext = {1'b0, elapsed} + (W+1)'(1);
    assign expired  = run && (next_ext >= {1'b0, limit});
endmodule

// File: rtl/rs485_master_ctrl.sv
module rs485_master_ctrl
    import rs485_mst_pkg::*;
#(
    parameter int NODES   = 32,
    parameter int MAX_LEN = 16,
    parameter int TMO_W   = 16,
    parameter int SLAVE_W = $clog2(NODES),
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SLAVE_W-1:0] req_slave,
    input  logic [LEN_W-1:0]   req_tx_len,
    input  logic [LEN_W-1:0]   req_rx_len,
    input  logic [TMO_W-1:0]   req_timeout,
    input  logic               pl_valid,
    input  logic [7:0]         pl_data,
    output logic               pl_ready,
    output logic               utx_valid,
    output logic [7:0]         utx_data,
    input  logic               utx_ready,
    input  logic               utx_idle,
    input  logic               urx_valid,
    input  logic [7:0]         urx_data,
    output logic               drv_en,
    output logic               rpl_valid,
    output logic [7:0]         rpl_data,
    output logic               busy,
    output logic               done,
    output logic               st_timeout,
    output logic               st_bad_addr
);
    localparam int PAD_W = BYTE_W - SLAVE_W;

    mst_state_t         state_q, state_d;
    logic [SLAVE_W-1:0] slave_q;
    logic [LEN_W-1:0]   txlen_q, rxlen_q;
    logic [TMO_W-1:0]   tmo_q;
    logic [LEN_W-1:0]   tx_cnt, rx_cnt;
    logic               accept, bad_req;
    logic               pl_fire, last_pl, last_rpl, tmo_hit;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign bad_req  = accept && (req_slave == '0);
    assign pl_fire  = (state_q == ST_PAYLOAD) && pl_valid && utx_ready;
    assign last_pl  = pl_fire && (tx_cnt == txlen_q - LEN_W'(1));
    assign last_rpl = rpl_valid && (rx_cnt == rxlen_q - LEN_W'(1));

    rs485_byte_counter #(.W(LEN_W)) u_tx_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .inc   (pl_fire),
        .count (tx_cnt)
    );

    rs485_byte_counter #(.W(LEN_W)) u_rx_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .inc   (rpl_valid),
        .count (rx_cnt)
    );

    rs485_reply_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_LISTEN),
        .limit   (tmo_q),
        .expired (tmo_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = bad_req ? ST_FINISH : ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (utx_ready) begin
                    state_d = (txlen_q == '0) ? ST_DRAIN : ST_PAYLOAD;
                end
            end
            ST_PAYLOAD: begin
                if (last_pl) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (utx_idle) begin
                    state_d = (rxlen_q == '0) ? ST_FINISH : ST_LISTEN;
                end
            end
            ST_LISTEN: begin
                if (last_rpl || tmo_hit) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            slave_q     <= '0;
            txlen_q     <= '0;
            rxlen_q     <= '0;
            tmo_q       <= '0;
            st_timeout  <= 1'b0;
            st_bad_addr <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                slave_q     <= req_slave;
                txlen_q     <= req_tx_len;
                rxlen_q     <= req_rx_len;
                tmo_q       <= req_timeout;
                st_timeout  <= 1'b0;
                st_bad_addr <= bad_req;
            end else if (state_q == ST_LISTEN && tmo_hit && !last_rpl) begin
                st_timeout <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        pl_ready  = 1'b0;
        utx_valid = 1'b0;
        utx_data  = '0;
        drv_en    = 1'b0;
        rpl_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ADDR: begin
                drv_en    = 1'b1;
                utx_valid = 1'b1;
                utx_data  = {{PAD_W{1'b0}}, slave_q};
            end
            ST_PAYLOAD: begin
                drv_en    = 1'b1;
                utx_valid = pl_valid;
                utx_data  = pl_data;
                pl_ready  = utx_ready;
            end
            ST_DRAIN:  drv_en = 1'b1;
            ST_LISTEN: rpl_valid = urx_valid;
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign rpl_data = urx_data;
    assign busy     = (state_q != ST_IDLE);

    // R2: never offer a byte to the transmitter with the driver off
    a_r2_offer_needs_driver: assert property (@(posedge clk) disable iff (!rst_n)
        utx_valid |-> drv_en);

    // R3: the driver is released only after the transmitter was empty
    a_r3_release_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> $past(utx_idle));

    // R1: the first offered byte after the driver turns on is the identifier
    a_r1_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> (utx_valid && utx_data == {{PAD_W{1'b0}}, slave_q}));

    // R4: no reply forwarding while the bus is driven
    a_r4_no_echo_forward: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_valid |-> !drv_en);

    // R7: ready and busy never overlap
    a_r7_ready_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the timeout flag rises only with completion
    a_r6_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_timeout) |-> done);
endmodule

// File: tb/tb_rs485_master_ctrl.sv
module tb_rs485_master_ctrl;
    localparam int LEN_W = 5;
    localparam int TMO_W = 16;
    localparam int SHIFT_CYC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [4:0]       req_slave = '0;
    logic [LEN_W-1:0] req_tx_len = '0;
    logic [LEN_W-1:0] req_rx_len = '0;
    logic [TMO_W-1:0] req_timeout = '0;
    logic             pl_valid, pl_ready;
    logic [7:0]       pl_data;
    logic             utx_valid, utx_ready, utx_idle;
    logic [7:0]       utx_data;
    logic             urx_valid = 1'b0;
    logic [7:0]       urx_data = '0;
    logic             drv_en, rpl_valid, busy, done, st_timeout, st_bad_addr;
    logic [7:0]       rpl_data;

    rs485_master_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_slave(req_slave),
        .req_tx_len(req_tx_len), .req_rx_len(req_rx_len), .req_timeout(req_timeout),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
        .utx_valid(utx_valid), .utx_data(utx_data), .utx_ready(utx_ready), .utx_idle(utx_idle),
        .urx_valid(urx_valid), .urx_data(urx_data),
        .drv_en(drv_en), .rpl_valid(rpl_valid), .rpl_data(rpl_data),
        .busy(busy), .done(done), .st_timeout(st_timeout), .st_bad_addr(st_bad_addr)
    );

    int checks = 0;
    int fails  = 0;

    // payload source
    logic [7:0] pl_arr [16];
    int pl_n = 0;
    int pl_idx = 0;
    assign pl_valid = (pl_idx < pl_n);
    assign pl_data  = pl_arr[pl_idx[3:0]];
    always @(posedge clk) if (pl_valid && pl_ready) pl_idx <= pl_idx + 1;

    // transmitter model: drops idle at the accepting edge
    logic ushift = 1'b0;
    int   ucnt = 0;
    logic [7:0] tx_log [32];
    int   tx_n = 0;
    assign utx_ready = !ushift;
    assign utx_idle  = !ushift;
    always @(posedge clk) begin
        if (!ushift && utx_valid) begin
            tx_log[tx_n[4:0]] <= utx_data;
            tx_n   <= tx_n + 1;
            ushift <= 1'b1;
            ucnt   <= SHIFT_CYC;
        end else if (ushift) begin
            if (ucnt == 1) ushift <= 1'b0;
            ucnt <= ucnt - 1;
        end
    end

    // reply capture and driver monitors
    logic [7:0] rp_log [32];
    int rp_n = 0;
    int drv_viol = 0;
    int drv_high = 0;
    always @(posedge clk) if (rpl_valid) begin
        rp_log[rp_n[4:0]] <= rpl_data;
        rp_n <= rp_n + 1;
    end
    always @(negedge clk) begin
        if (ushift && !drv_en) drv_viol++;
        if (drv_en) drv_high++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int since_drop;

    task automatic run_txn(input logic [4:0] slave, input int ntx, input int nrx,
                           input int tmo, input int nreply, input bit echo,
                           input bit poke_busy);
        bit seen_high = 0;
        bit echo_pend = echo;
        bit poked = 0;
        int sent = 0;
        @(negedge clk);
        tx_n = 0; rp_n = 0; pl_idx = 0; drv_viol = 0; drv_high = 0;
        for (int i = 0; i < ntx; i++) pl_arr[i] = 8'h90 + 8'(i * 7);
        pl_n = ntx;
        req_slave = slave; req_tx_len = LEN_W'(ntx); req_rx_len = LEN_W'(nrx);
        req_timeout = TMO_W'(tmo); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        since_drop = 0;
        for (int c = 0; c < 2000; c++) begin
            urx_valid = 1'b0;
            req_valid = 1'b0;
            if (drv_en) seen_high = 1;
            if (drv_en && echo_pend) begin
                urx_valid = 1'b1; urx_data = 8'hEE; echo_pend = 0;
            end
            if (drv_en && poke_busy && !poked) begin
                req_valid = 1'b1; req_slave = 5'd9; poked = 1;
            end
            if ((seen_high || slave == 0) && !drv_en) begin
                since_drop++;
                if (since_drop % 3 == 1 && sent < nreply && !done) begin
                    urx_valid = 1'b1; urx_data = 8'h40 + 8'(sent); sent++;
                end
            end
            if (done) break;
            @(negedge clk);
        end
        urx_valid = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 busy", busy, 0);
        check("R10 drv_en", drv_en, 0);
        check("R10 done", done, 0);
        check("R10 req_ready", req_ready, 1);
        check("R10 flags", {st_timeout, st_bad_addr}, 0);
    endtask

    task automatic t_normal;
        run_txn(5'd5, 3, 2, 200, 2, 1'b1, 1'b0);
        check("R1 byte count", tx_n, 4);
        check("R1 addr byte", tx_log[0], 8'h05);
        for (int i = 0; i < 3; i++) check("R1 payload", tx_log[i+1], 8'h90 + i * 7);
        check("R2 drv during shift", drv_viol, 0);
        check("R4 echo dropped, reply count", rp_n, 2);
        check("R4 reply byte0", rp_log[0], 8'h40);
        check("R5 reply byte1", rp_log[1], 8'h41);
        check("R6 no timeout", st_timeout, 0);
        @(negedge clk);
        check("R9 done pulse", done, 0);
        check("R7 idle after", busy, 0);
    endtask

    task automatic t_timeout;
        run_txn(5'd17, 1, 3, 20, 1, 1'b0, 1'b0);
        check("R6 timeout flag", st_timeout, 1);
        check("R6 window length", since_drop, 21);
        check("R6 partial reply", rp_n, 1);
        repeat (4) @(negedge clk);
        check("R9 flag held", st_timeout, 1);
    endtask

    task automatic t_tmo_zero;
        run_txn(5'd3, 0, 1, 0, 0, 1'b0, 1'b0);
        check("R6 zero acts as one", since_drop, 2);
        check("R6 zero timeout flag", st_timeout, 1);
    endtask

    task automatic t_bad_addr;
        run_txn(5'd0, 2, 1, 50, 0, 1'b0, 1'b0);
        check("R8 bad flag", st_bad_addr, 1);
        check("R8 no bytes", tx_n, 0);
        check("R8 no driver", drv_high, 0);
    endtask

    task automatic t_zero_len;
        run_txn(5'd31, 0, 0, 50, 0, 1'b0, 1'b0);
        check("R1 addr only", tx_n, 1);
        check("R1 addr value", tx_log[0], 8'h1F);
        check("R5 rx_len zero ends at release", since_drop, 1);
        check("R5 nothing forwarded", rp_n, 0);
        check("R2 drv during shift", drv_viol, 0);
        check("R9 bad flag cleared", st_bad_addr, 0);
        check("R9 timeout flag cleared", st_timeout, 0);
    endtask

    task automatic t_busy_req;
        run_txn(5'd12, 2, 1, 100, 1, 1'b0, 1'b1);
        check("R7 one addr byte", tx_n, 3);
        check("R7 addr kept", tx_log[0], 8'h0C);
        repeat (10) @(negedge clk);
        check("R7 no new txn", busy, 0);
        check("R7 no extra bytes", tx_n, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_timeout();
        t_tmo_zero();
        t_bad_addr();
        t_zero_len();
        t_busy_req();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule